// File: doc/BRIEF.md
# Buffer Ownership Contract Checker

This block watches one endpoint of a descriptor queue and judges each operation against an ownership contract. The endpoint can do four things. It can claim a memory region. It can release a region. It can hand a buffer to its peer (enqueue). It can take a buffer back (dequeue). The checker keeps two tables. The first holds the claimed regions, each with a base address and a size. The second holds the buffers that are currently out of the endpoint's hands, each recorded as region id, offset and length. Every operation gets a verdict one cycle later: accept or reject, a 3-bit reason code, and a region id.

A buffer handed out cannot be handed out again, and no other buffer that overlaps it may be handed out, until it has been taken back. A region cannot be released while any of its buffers are still out. A circular history of the latest eight operations can be read at any time by age, for post-mortem inspection. The checker only observes and records. It does not move descriptors and does not touch memory.

Top module: `own_checker`

## Requirements
- R1: After reset there is no result pulse, the history reports no valid entry, and both tables are empty, so the first region claim receives id 0.
- R2: Region claim (op 0) uses `ev_off` as the base and `ev_len` as the size. The checks run in this order: size 0 gives code 1 (bounds); a range that intersects any claimed region gives code 2 (overlap); a full region table gives code 7 (no space). On success the result returns the lowest free id. On failure the result returns `ev_rid`.
- R3: Enqueue (op 2) on an id that is not claimed gives code 4 (unknown region). A zero length, or offset plus length larger than the region size, gives code 1.
- R4: The valid window must fit inside its buffer: valid offset plus valid length must not exceed length. Otherwise an enqueue or a dequeue gets code 1.
- R5: An enqueue whose byte range intersects a buffer that is already out in the same region gives code 2. This includes handing out the identical buffer twice.
- R6: An otherwise legal enqueue that arrives while the buffer table is full gives code 7.
- R7: A dequeue (op 3) must match an outstanding buffer exactly in id, offset and length, or it gets code 3 (not owned). An accepted dequeue removes that entry, so the same buffer may then be enqueued again.
- R8: A dequeue while no buffer is outstanding gives code 6 (empty) and changes no table. This check takes precedence over the others.
- R9: Region release (op 1) on an id that is not claimed gives code 4. If any buffer of that region is outstanding it gives code 5 (busy). On success the id becomes free and is reused by the next claim.
- R10: The history holds the last 8 operations. Age 0 is the newest. Each entry records the op, the reported id, the offset and the code. Ages that have not been written yet read as not valid.
- R11: Each event produces exactly one result, in the next cycle. `res_ok` is high exactly when the code is 0. A rejected event leaves both tables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 2 | 0 claim, 1 release, 2 enqueue, 3 dequeue |
| ev_rid | input | RIDW | Region id |
| ev_off | input | AW | Buffer offset, or region base for a claim |
| ev_len | input | AW | Buffer length, or region size for a claim |
| ev_voff | input | AW | Valid-data offset within the buffer |
| ev_vlen | input | AW | Valid-data length |
| res_valid | output | 1 | Verdict present |
| res_ok | output | 1 | Event accepted |
| res_err | output | 3 | Reason code |
| res_rid | output | RIDW | Assigned id for an accepted claim, else the event id |
| log_age | input | LW | History entry to read, 0 = newest |
| log_vld | output | 1 | Selected entry exists |
| log_op | output | 2 | Recorded op |
| log_rid | output | RIDW | Recorded id |
| log_off | output | AW | Recorded offset |
| log_err | output | 3 | Recorded code |

## Verification
The embedded assertions assume that `ev_valid` is a clean single-cycle strobe and that `ev_rid` is always inside the table range. The bench drives each event for exactly one cycle with idle gaps between events, and it only uses ids below the region count. Table updates are expected only on accepted events, so the assertions take the table-full and hit indications at face value. The stimulus reaches the full conditions of both tables through legal operations rather than by forcing them.

// File: rtl/own_pkg.sv
// Shared operation and reason encodings for the ownership checker.
// Assumes: consumers cast the 2-bit and 3-bit port fields to these types.
package own_pkg;
    typedef enum logic [1:0] {
        OP_CLAIM   = 2'd0,
        OP_RELEASE = 2'd1,
        OP_ENQ     = 2'd2,
        OP_DEQ     = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_BOUNDS  = 3'd1,
        RC_OVERLAP = 3'd2,
        RC_NOTOWN  = 3'd3,
        RC_NOREG   = 3'd4,
        RC_BUSY    = 3'd5,
        RC_EMPTY   = 3'd6,
        RC_NOSPACE = 3'd7
    } rc_e;
endpackage

// File: rtl/own_region_tbl.sv
// Region table: NREG claimed address ranges (base, size).
// Provides lookup of one id, an overlap test for a candidate range and the
// lowest free slot. Assumes set and clr are never asserted for the same id
// in one cycle and that set only targets a free slot.
module own_region_tbl #(
    parameter int NREG = 4,
    parameter int AW   = 16,
    localparam int RIDW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDW-1:0] q_rid,
    input  logic [AW-1:0]   q_base,
    input  logic [AW-1:0]   q_size,
    input  logic            set,
    input  logic [RIDW-1:0] set_idx,
    input  logic            clr,
    output logic            rid_vld,
    output logic [AW-1:0]   rid_size,
    output logic            range_hit,
    output logic            free_avail,
    output logic [RIDW-1:0] free_idx
);
    logic [NREG-1:0] vld;
    logic [AW-1:0]   base [NREG];
    logic [AW-1:0]   size [NREG];
    logic [NREG-1:0] hit;

    // Claim and release bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (set) begin
                vld[set_idx]  <= 1'b1;
                base[set_idx] <= q_base;
                size[set_idx] <= q_size;
            end
            if (clr) vld[q_rid] <= 1'b0;
        end
    end

    // Per-entry interval intersection with the candidate range.
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        always_comb begin
            hit[i] = vld[i]
                && ({1'b0, q_base} < ({1'b0, base[i]} + {1'b0, size[i]}))
                && ({1'b0, base[i]} < ({1'b0, q_base} + {1'b0, q_size}));
        end
    end

    // Lookup, overlap summary and lowest free slot.
    always_comb begin
        rid_vld    = vld[q_rid];
        rid_size   = size[q_rid];
        range_hit  = |hit;
        free_avail = ~&vld;
        free_idx   = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = RIDW'(i);
        end
    end

    a_r2_claim_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        set |-> !vld[set_idx]);
    a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !vld[$past(q_rid)]);
endmodule

// File: rtl/own_buf_tbl.sv
// Outstanding-buffer table: NBUF entries of (region id, offset, length).
// Reports range overlap and exact match against the query, per-region
// occupancy, and fill level. Assumes ins only when not full and rem only on
// an exact hit.
module own_buf_tbl #(
    parameter int NBUF = 16,
    parameter int RIDW = 2,
    parameter int AW   = 16,
    localparam int BIW = $clog2(NBUF),
    localparam int CW  = $clog2(NBUF + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDW-1:0] q_rid,
    input  logic [AW-1:0]   q_off,
    input  logic [AW-1:0]   q_len,
    input  logic            ins,
    input  logic            rem,
    output logic            overlap,
    output logic            exact_hit,
    output logic            rid_busy,
    output logic            full,
    output logic            empty,
    output logic [CW-1:0]   cnt
);
    logic [NBUF-1:0] vld, ov, ex, same;
    logic [RIDW-1:0] e_rid [NBUF];
    logic [AW-1:0]   e_off [NBUF];
    logic [AW-1:0]   e_len [NBUF];
    logic [BIW-1:0]  free_idx, hit_idx;

    // Insert into the lowest free slot, remove the matched slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (ins) begin
                vld[free_idx]   <= 1'b1;
                e_rid[free_idx] <= q_rid;
                e_off[free_idx] <= q_off;
                e_len[free_idx] <= q_len;
            end
            if (rem) vld[hit_idx] <= 1'b0;
        end
    end

    // Per-entry comparisons against the query.
    for (genvar i = 0; i < NBUF; i++) begin : g_cmp
        always_comb begin
            same[i] = vld[i] && (e_rid[i] == q_rid);
            ov[i]   = same[i]
                && ({1'b0, q_off} < ({1'b0, e_off[i]} + {1'b0, e_len[i]}))
                && ({1'b0, e_off[i]} < ({1'b0, q_off} + {1'b0, q_len}));
            ex[i]   = same[i] && (e_off[i] == q_off) && (e_len[i] == q_len);
        end
    end

    // Summaries, slot selection and fill count.
    always_comb begin
        overlap   = |ov;
        exact_hit = |ex;
        rid_busy  = |same;
        free_idx  = '0;
        hit_idx   = '0;
        cnt       = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = BIW'(i);
            if (ex[i])   hit_idx  = BIW'(i);
        end
        for (int i = 0; i < NBUF; i++) cnt = cnt + CW'(vld[i]);
        full  = (cnt == CW'(NBUF));
        empty = (cnt == '0);
    end

    a_r6_insert_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> !full);
    a_r5_insert_unique: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> !overlap);
    a_r7_remove_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rem |-> exact_hit);
    a_r7_remove_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (rem && !ins) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/own_log.sv
// Circular history of the last DEPTH operations, read by age (0 = newest).
// Assumes DEPTH is a power of two.
module own_log #(
    parameter int DEPTH = 8,
    parameter int RIDW  = 2,
    parameter int AW    = 16,
    localparam int LW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [1:0]      w_op,
    input  logic [RIDW-1:0] w_rid,
    input  logic [AW-1:0]   w_off,
    input  logic [2:0]      w_err,
    input  logic [LW-1:0]   rd_age,
    output logic            rd_vld,
    output logic [1:0]      rd_op,
    output logic [RIDW-1:0] rd_rid,
    output logic [AW-1:0]   rd_off,
    output logic [2:0]      rd_err
);
    logic [1:0]      h_op  [DEPTH];
    logic [RIDW-1:0] h_rid [DEPTH];
    logic [AW-1:0]   h_off [DEPTH];
    logic [2:0]      h_err [DEPTH];
    logic [LW-1:0]   wp, rp;
    logic [LW:0]     fill;

    // Append one record and advance the pointer; fill saturates at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            fill <= '0;
        end else if (wr) begin
            h_op[wp]  <= w_op;
            h_rid[wp] <= w_rid;
            h_off[wp] <= w_off;
            h_err[wp] <= w_err;
            wp        <= wp + LW'(1);
            if (fill != (LW+1)'(DEPTH)) fill <= fill + (LW+1)'(1);
        end
    end

    // Age-indexed read port.
    always_comb begin
        rp     = wp - LW'(1) - rd_age;
        rd_vld = ({1'b0, rd_age} < fill);
        rd_op  = h_op[rp];
        rd_rid = h_rid[rp];
        rd_off = h_off[rp];
        rd_err = h_err[rp];
    end

    a_r10_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && fill != (LW+1)'(DEPTH)) |=> (fill == $past(fill) + (LW+1)'(1)));
endmodule

// File: rtl/own_checker.sv
// Ownership contract checker top. Classifies each event against the region
// and outstanding-buffer tables, updates them on acceptance, registers the
// verdict for one cycle and appends it to the history.
// Assumes ev_valid is a single-cycle strobe per event.
module own_checker #(
    parameter int NREG  = 4,
    parameter int NBUF  = 16,
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int RIDW = $clog2(NREG),
    localparam int LW   = $clog2(DEPTH),
    localparam int CW   = $clog2(NBUF + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    input  logic [1:0]      ev_op,
    input  logic [RIDW-1:0] ev_rid,
    input  logic [AW-1:0]   ev_off,
    input  logic [AW-1:0]   ev_len,
    input  logic [AW-1:0]   ev_voff,
    input  logic [AW-1:0]   ev_vlen,
    output logic            res_valid,
    output logic            res_ok,
    output logic [2:0]      res_err,
    output logic [RIDW-1:0] res_rid,
    input  logic [LW-1:0]   log_age,
    output logic            log_vld,
    output logic [1:0]      log_op,
    output logic [RIDW-1:0] log_rid,
    output logic [AW-1:0]   log_off,
    output logic [2:0]      log_err
);
    import own_pkg::*;

    op_e             op;
    rc_e             rc;
    logic [RIDW-1:0] rid_out;
    logic            rid_vld, range_hit, free_avail;
    logic [AW-1:0]   rid_size;
    logic [RIDW-1:0] free_idx;
    logic            b_ov, b_hit, b_busy, b_full, b_empty;
    logic [CW-1:0]   b_cnt;
    logic            in_bounds, win_ok;
    logic            do_claim, do_release, do_ins, do_rem;

    assign op = op_e'(ev_op);

    own_region_tbl #(.NREG(NREG), .AW(AW)) u_reg (
        .clk(clk), .rst_n(rst_n), .q_rid(ev_rid), .q_base(ev_off),
        .q_size(ev_len), .set(do_claim), .set_idx(free_idx),
        .clr(do_release), .rid_vld(rid_vld), .rid_size(rid_size),
        .range_hit(range_hit), .free_avail(free_avail), .free_idx(free_idx)
    );

    own_buf_tbl #(.NBUF(NBUF), .RIDW(RIDW), .AW(AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .q_rid(ev_rid), .q_off(ev_off),
        .q_len(ev_len), .ins(do_ins), .rem(do_rem), .overlap(b_ov),
        .exact_hit(b_hit), .rid_busy(b_busy), .full(b_full),
        .empty(b_empty), .cnt(b_cnt)
    );

    // Contract classification with fixed per-op check priority.
    always_comb begin
        in_bounds = (ev_len != '0)
            && (({1'b0, ev_off} + {1'b0, ev_len}) <= {1'b0, rid_size});
        win_ok    = ({1'b0, ev_voff} + {1'b0, ev_vlen}) <= {1'b0, ev_len};
        rc        = RC_OK;
        rid_out   = ev_rid;
        unique case (op)
            OP_CLAIM: begin
                if (ev_len == '0)     rc = RC_BOUNDS;
                else if (range_hit)   rc = RC_OVERLAP;
                else if (!free_avail) rc = RC_NOSPACE;
                else                  rid_out = free_idx;
            end
            OP_RELEASE: begin
                if (!rid_vld)         rc = RC_NOREG;
                else if (b_busy)      rc = RC_BUSY;
            end
            OP_ENQ: begin
                if (!rid_vld)         rc = RC_NOREG;
                else if (!in_bounds || !win_ok) rc = RC_BOUNDS;
                else if (b_ov)        rc = RC_OVERLAP;
                else if (b_full)      rc = RC_NOSPACE;
            end
            OP_DEQ: begin
                if (b_empty)          rc = RC_EMPTY;
                else if (!rid_vld)    rc = RC_NOREG;
                else if (!in_bounds || !win_ok) rc = RC_BOUNDS;
                else if (!b_hit)      rc = RC_NOTOWN;
            end
            default: rc = RC_OK;
        endcase
        do_claim   = ev_valid && (op == OP_CLAIM)   && (rc == RC_OK);
        do_release = ev_valid && (op == OP_RELEASE) && (rc == RC_OK);
        do_ins     = ev_valid && (op == OP_ENQ)     && (rc == RC_OK);
        do_rem     = ev_valid && (op == OP_DEQ)     && (rc == RC_OK);
    end

    // One-cycle registered verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_ok    <= 1'b0;
            res_err   <= '0;
            res_rid   <= '0;
        end else begin
            res_valid <= ev_valid;
            res_ok    <= ev_valid && (rc == RC_OK);
            res_err   <= ev_valid ? rc : 3'd0;
            res_rid   <= ev_valid ? rid_out : '0;
        end
    end

    own_log #(.DEPTH(DEPTH), .RIDW(RIDW), .AW(AW)) u_log (
        .clk(clk), .rst_n(rst_n), .wr(ev_valid), .w_op(ev_op),
        .w_rid(rid_out), .w_off(ev_off), .w_err(rc), .rd_age(log_age),
        .rd_vld(log_vld), .rd_op(log_op), .rd_rid(log_rid),
        .rd_off(log_off), .rd_err(log_err)
    );

    a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> res_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !res_valid);
    a_r8_empty_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && op == OP_DEQ && b_empty) |=> $stable(b_cnt));
    a_r11_reject_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (op == OP_ENQ) && (rc != RC_OK)) |=> $stable(b_cnt));
endmodule

// File: tb/own_checker_test.sv
// Scoreboard bench: the driver pushes expected verdicts, the monitor pops and
// compares them when res_valid appears; history is checked at the end.
module own_checker_test;
    localparam int RIDW = 2;
    localparam int AW   = 16;
    localparam int LW   = 3;

    localparam logic [2:0] OK = 3'd0, BND = 3'd1, OVL = 3'd2, NOWN = 3'd3,
                           NREG = 3'd4, BUSY = 3'd5, EMPTY = 3'd6, NOSP = 3'd7;
    localparam logic [1:0] CLAIM = 2'd0, REL = 2'd1, ENQ = 2'd2, DEQ = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0;
    logic [1:0] ev_op = '0;
    logic [RIDW-1:0] ev_rid = '0;
    logic [AW-1:0] ev_off = '0, ev_len = '0, ev_voff = '0, ev_vlen = '0;
    logic res_valid, res_ok;
    logic [2:0] res_err;
    logic [RIDW-1:0] res_rid;
    logic [LW-1:0] log_age = '0;
    logic log_vld;
    logic [1:0] log_op;
    logic [RIDW-1:0] log_rid;
    logic [AW-1:0] log_off;
    logic [2:0] log_err;

    int checks = 0;
    int fails  = 0;

    logic [2:0]      q_err [$];
    logic [RIDW-1:0] q_rid [$];
    string           q_tag [$];
    logic [1:0]      h_op  [$];
    logic [RIDW-1:0] h_rid [$];
    logic [AW-1:0]   h_off [$];
    logic [2:0]      h_err [$];

    always #2 clk = ~clk;

    own_checker uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op),
        .ev_rid(ev_rid), .ev_off(ev_off), .ev_len(ev_len),
        .ev_voff(ev_voff), .ev_vlen(ev_vlen), .res_valid(res_valid),
        .res_ok(res_ok), .res_err(res_err), .res_rid(res_rid),
        .log_age(log_age), .log_vld(log_vld), .log_op(log_op),
        .log_rid(log_rid), .log_off(log_off), .log_err(log_err)
    );

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one-cycle event plus its expected verdict.
    task automatic ev(input logic [1:0] op, input logic [RIDW-1:0] rid,
                      input int off, input int len, input int voff, input int vlen,
                      input logic [2:0] e_err, input logic [RIDW-1:0] e_rid,
                      input string tag);
        @(negedge clk);
        ev_valid = 1'b1; ev_op = op; ev_rid = rid;
        ev_off = AW'(off); ev_len = AW'(len); ev_voff = AW'(voff); ev_vlen = AW'(vlen);
        q_err.push_back(e_err); q_rid.push_back(e_rid); q_tag.push_back(tag);
        h_op.push_back(op); h_rid.push_back(e_rid);
        h_off.push_back(AW'(off)); h_err.push_back(e_err);
        @(posedge clk);
        #1 ev_valid = 1'b0;
    endtask

    // Monitor: compare each verdict with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q_err.size() == 0) begin
                check(1'b0, "R11 unexpected result", 1, 0);
            end else begin
                logic [2:0] e; logic [RIDW-1:0] r; string t;
                e = q_err.pop_front(); r = q_rid.pop_front(); t = q_tag.pop_front();
                check(res_err == e, {t, " code"}, res_err, e);
                check(res_rid == r, {t, " rid"}, res_rid, r);
                check(res_ok == (e == OK), {t, " R11 ok flag"}, res_ok, e == OK);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
        #1 check(log_vld == 1'b0, "R1 history empty", log_vld, 0);

        // R1 R2: claims
        ev(CLAIM, 2'd0, 0,   256, 0, 0, OK,   2'd0, "R1 R2 first claim id0");
        ev(CLAIM, 2'd0, 200, 100, 0, 0, OVL,  2'd0, "R2 overlapping claim");
        ev(CLAIM, 2'd2, 256, 0,   0, 0, BND,  2'd2, "R2 zero size claim");
        ev(CLAIM, 2'd0, 256, 256, 0, 0, OK,   2'd1, "R2 second claim id1");
        // R3 R4: enqueue bounds
        ev(ENQ, 2'd2, 0,   16, 0, 0,  NREG, 2'd2, "R3 unknown region");
        ev(ENQ, 2'd0, 250, 10, 0, 0,  BND,  2'd0, "R3 past region end");
        ev(ENQ, 2'd0, 0,   0,  0, 0,  BND,  2'd0, "R3 zero length");
        ev(ENQ, 2'd0, 0,   64, 60, 8, BND,  2'd0, "R4 window outside buffer");
        ev(ENQ, 2'd0, 0,   64, 0, 64, OK,   2'd0, "R4 R3 legal enqueue");
        // R5: overlap
        ev(ENQ, 2'd0, 0,  64, 0, 0, OVL, 2'd0, "R5 double enqueue");
        ev(ENQ, 2'd0, 32, 64, 0, 0, OVL, 2'd0, "R5 partial overlap");
        ev(ENQ, 2'd1, 0,  64, 0, 0, OK,  2'd1, "R5 other region same offset");
        // R9: release checks
        ev(REL, 2'd0, 0, 0, 0, 0, BUSY, 2'd0, "R9 release busy");
        ev(REL, 2'd3, 0, 0, 0, 0, NREG, 2'd3, "R9 release unknown");
        // R7 R4: dequeue
        ev(DEQ, 2'd0, 0, 32, 0, 0,  NOWN, 2'd0, "R7 length mismatch");
        ev(DEQ, 2'd0, 0, 64, 8, 60, BND,  2'd0, "R4 dequeue window");
        ev(DEQ, 2'd0, 0, 64, 0, 64, OK,   2'd0, "R7 matching dequeue");
        ev(DEQ, 2'd0, 0, 64, 0, 0,  NOWN, 2'd0, "R7 already taken back");
        ev(DEQ, 2'd1, 0, 64, 0, 0,  OK,   2'd1, "R7 dequeue region1");
        // R8: empty
        ev(DEQ, 2'd0, 0, 64, 0, 0, EMPTY, 2'd0, "R8 empty dequeue");
        ev(DEQ, 2'd3, 0, 64, 0, 0, EMPTY, 2'd3, "R8 empty has priority");
        ev(ENQ, 2'd0, 0, 64, 0, 0, OK,    2'd0, "R7 re-enqueue after dequeue");
        // R9 R2: release then reuse, fill region table
        ev(REL,   2'd1, 0,   0,  0, 0, OK,   2'd1, "R9 release idle region");
        ev(CLAIM, 2'd0, 600, 16, 0, 0, OK,   2'd1, "R9 id reused");
        ev(CLAIM, 2'd0, 700, 16, 0, 0, OK,   2'd2, "R2 claim id2");
        ev(CLAIM, 2'd0, 800, 16, 0, 0, OK,   2'd3, "R2 claim id3");
        ev(CLAIM, 2'd0, 900, 16, 0, 0, NOSP, 2'd0, "R2 region table full");
        // R6: fill buffer table (one already out)
        for (int i = 0; i < 15; i++)
            ev(ENQ, 2'd0, 64 + 4*i, 4, 0, 0, OK, 2'd0, "R6 fill");
        ev(ENQ, 2'd0, 128, 4, 0, 0, NOSP, 2'd0, "R6 buffer table full");
        ev(ENQ, 2'd0, 64,  4, 0, 0, OVL,  2'd0, "R6 overlap before no-space");

        repeat (3) @(negedge clk);
        check(q_err.size() == 0, "R11 all results seen", q_err.size(), 0);

        // R10: history by age
        for (int a = 0; a < 8; a++) begin
            int k;
            k = h_op.size() - 1 - a;
            log_age = LW'(a);
            #1;
            check(log_vld == 1'b1, "R10 entry valid", log_vld, 1);
            check(log_op == h_op[k], "R10 op", log_op, h_op[k]);
            check(log_rid == h_rid[k], "R10 rid", log_rid, h_rid[k]);
            check(log_off == h_off[k], "R10 off", log_off, h_off[k]);
            check(log_err == h_err[k], "R10 err", log_err, h_err[k]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule